// File: doc/BRIEF.md
# Multiplexed-Bus Memory and Register Front End

This block sits between an 8-bit shared address/data bus and the inside of a combined memory and I/O peripheral. At the falling edge of the address strobe it captures, all at once, the byte on the bus, the chip-select level and the memory-or-register space select. These captured values, not the live pins, decide where the following read or write goes. Either a 256-byte memory held in the block or a small window of register offsets is the target. Offset 0 is the command register, which is kept locally. Offsets 1 to 5 are passed out as one-cycle read and write strobes for the port and timer logic that lies outside.

All inputs are sampled on a single system clock, and strobes act on their leading (falling) edge. Read data is returned combinationally while the read strobe is low. The bus driver is modelled as a data output plus an output-enable, so a pad ring or a tri-state wrapper can build the real bidirectional pin. The polarity of the chip select is fixed when the block is built. The bus here is a strobe protocol with no back-pressure, so no valid/ready handshake applies.

Top module: `mbus_frontend`

## Requirements
- R1: The bus byte is stored as the access address only on a clock where the address strobe was high on the previous clock and is low now. Later changes of the bus byte do not move the target of the access.
- R2: The chip-select level and the space select are stored on that same clock. Changing either pin after the capture does not change where the access goes or whether it is served.
- R3: A stored space select of 0 sends accesses to the memory. A stored space select of 1 sends them to the register window, and the memory is then neither read nor written.
- R4: While the block is selected, read is low and write is high, the output-enable is 1 and the output carries the addressed byte. When the block is not selected or read is high, the output-enable is 0.
- R5: A write stores the bus byte once, on the first clock that write is seen low while the block is selected. Bus changes while write stays low are not stored, and a write while not selected changes nothing.
- R6: Parameter CE_HIGH=0 treats a chip-enable pin level of 0 as selected. CE_HIGH=1 treats a level of 1 as selected.
- R7: While reset is high, the captured select and the command register are cleared. This leaves both port directions as input (dir_a=0, dir_b=0), pc_mode=0 and the bus not driven.
- R8: Reset does not alter the memory contents.
- R9: When read and write are low together, the write is performed, the output-enable stays 0 and no register read strobe is issued.
- R10: A register write to offset 0 loads the command register: bit 0 goes to dir_a, bit 1 to dir_b and bits 3:2 to pc_mode. It raises no external write strobe. A read of offset 0 returns reg_rdata (status).
- R11: Register offsets 1 to 5 produce a one-cycle reg_wr_stb on a write, and offsets 0 to 5 produce a one-cycle reg_rd_stb on a read. During these strobes reg_addr carries the low three address bits. Register addresses 6 and above raise no strobe, ignore writes and read as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ale | input | 1 | Address strobe; capture on its falling edge |
| chip_en | input | 1 | Chip enable, polarity set by CE_HIGH |
| io_sel | input | 1 | Space select: 0 memory, 1 registers |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| ad_in | input | 8 | Bus value seen at the pins |
| ad_out | output | 8 | Read data toward the bus |
| ad_oe | output | 1 | Bus driver enable |
| reg_addr | output | 3 | Register offset for external registers |
| reg_wdata | output | 8 | Write data for external registers |
| reg_wr_stb | output | 1 | One-cycle external register write |
| reg_rd_stb | output | 1 | One-cycle external register read |
| reg_rdata | input | 8 | Read data / status from external registers |
| dir_a | output | 1 | Port A direction (1 = output) |
| dir_b | output | 1 | Port B direction (1 = output) |
| pc_mode | output | 2 | Port C mode field |

## Verification
The hardest case to reach is a change on the select pins between the address capture and the data strobe. A capture of this kind is only visible when the pins that drove it have since moved, so the stimulus first captures an address and then flips chip enable and space select, as well as garbage on the bus. Only after that does it strobe, and it expects the original target to answer. A second instance built with the opposite chip-select polarity shares the same pins. It must therefore answer exactly the accesses the first one ignores, and memory that survives a mid-run reset is read back after the reset has been released.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  // command register layout: field positions are decoded by port logic
  typedef struct packed {
    logic [1:0] pc_mode;  // bits 3:2
    logic       dir_b;    // bit 1
    logic       dir_a;    // bit 0
  } cmd_t;

  localparam int CMD_W = $bits(cmd_t);

  function automatic logic sel_level(input logic pin, input logic active_high);
    return active_high ? pin : ~pin;
  endfunction
endpackage

// File: rtl/mbus_latch.sv
module mbus_latch #(
  parameter int ADDR_W  = 8,
  parameter bit CE_HIGH = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ale,
  input  logic [ADDR_W-1:0] ad_in,
  input  logic              chip_en,
  input  logic              io_sel,
  output logic [ADDR_W-1:0] lat_addr,
  output logic              lat_sel,
  output logic              lat_io
);
  logic ale_q;
  logic ale_fall;

  assign ale_fall = ale_q & ~ale;

  always_ff @(posedge clk) begin
    if (rst) begin
      ale_q    <= 1'b0;
      lat_addr <= '0;
      lat_sel  <= 1'b0;
      lat_io   <= 1'b0;
    end else begin
      ale_q <= ale;
      if (ale_fall) begin
        lat_addr <= ad_in;
        lat_sel  <= mbus_pkg::sel_level(chip_en, CE_HIGH);
        lat_io   <= io_sel;
      end
    end
  end
endmodule

// File: rtl/mbus_ram.sv
module mbus_ram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  // no reset: contents survive the block reset
  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
  end

  assign rdata = cells[addr];
endmodule

// File: rtl/mbus_regs.sv
module mbus_regs #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 8,
  parameter int IO_REGS = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_pulse,
  input  logic                 rd_pulse,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [mbus_pkg::CMD_W-1:0] cmd_wdata,
  input  logic [DATA_W-1:0]    ext_rdata,
  output mbus_pkg::cmd_t       cmd,
  output logic                 ext_wr,
  output logic                 ext_rd,
  output logic [DATA_W-1:0]    rdata
);
  logic hit;
  logic is_cmd;

  assign hit    = addr < ADDR_W'(IO_REGS);
  assign is_cmd = addr == '0;

  assign ext_wr = wr_pulse & hit & ~is_cmd;
  assign ext_rd = rd_pulse & hit;
  assign rdata  = hit ? ext_rdata : '0;

  always_ff @(posedge clk) begin
    if (rst)                    cmd <= '0;
    else if (wr_pulse & is_cmd) cmd <= mbus_pkg::cmd_t'(cmd_wdata);
  end
endmodule

// File: rtl/mbus_frontend.sv
module mbus_frontend #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 8,
  parameter int IO_REGS = 6,
  parameter bit CE_HIGH = 1'b0,
  localparam int OFF_W  = $clog2(IO_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ale,
  input  logic              chip_en,
  input  logic              io_sel,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] ad_in,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [OFF_W-1:0]  reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_wr_stb,
  output logic              reg_rd_stb,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              dir_a,
  output logic              dir_b,
  output logic [1:0]        pc_mode
);
  logic [ADDR_W-1:0] lat_addr;
  logic              lat_sel, lat_io;
  logic              rd_q, wr_q;
  logic              rd_act, wr_act, wr_pulse, rd_pulse;
  logic [DATA_W-1:0] ram_rdata, reg_rd;
  mbus_pkg::cmd_t    cmd;

  mbus_latch #(.ADDR_W(ADDR_W), .CE_HIGH(CE_HIGH)) u_latch (
    .clk(clk), .rst(rst), .ale(ale), .ad_in(ad_in[ADDR_W-1:0]),
    .chip_en(chip_en), .io_sel(io_sel),
    .lat_addr(lat_addr), .lat_sel(lat_sel), .lat_io(lat_io)
  );

  // strobe history, 1 = inactive
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= 1'b1;
      wr_q <= 1'b1;
    end else begin
      rd_q <= rd_n;
      wr_q <= wr_n;
    end
  end

  assign rd_act   = ~rd_n;
  assign wr_act   = ~wr_n;
  assign wr_pulse = lat_sel & wr_act & wr_q;
  assign rd_pulse = lat_sel & rd_act & rd_q & ~wr_act;

  mbus_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .we(wr_pulse & ~lat_io), .addr(lat_addr),
    .wdata(ad_in), .rdata(ram_rdata)
  );

  mbus_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IO_REGS(IO_REGS)) u_regs (
    .clk(clk), .rst(rst),
    .wr_pulse(wr_pulse & lat_io), .rd_pulse(rd_pulse & lat_io),
    .addr(lat_addr), .cmd_wdata(ad_in[mbus_pkg::CMD_W-1:0]),
    .ext_rdata(reg_rdata), .cmd(cmd),
    .ext_wr(reg_wr_stb), .ext_rd(reg_rd_stb), .rdata(reg_rd)
  );

  assign ad_oe     = lat_sel & rd_act & ~wr_act;
  assign ad_out    = lat_io ? reg_rd : ram_rdata;
  assign reg_addr  = lat_addr[OFF_W-1:0];
  assign reg_wdata = ad_in;
  assign dir_a     = cmd.dir_a;
  assign dir_b     = cmd.dir_b;
  assign pc_mode   = cmd.pc_mode;
endmodule

// File: rtl/mbus_chk.sv
module mbus_chk #(
  parameter int OFF_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             ale,
  input logic             rd_n,
  input logic             wr_n,
  input logic             ad_oe,
  input logic [OFF_W-1:0] reg_addr,
  input logic             reg_wr_stb,
  input logic             reg_rd_stb,
  input logic             dir_a,
  input logic             dir_b
);
  logic ale_d;
  always_ff @(posedge clk) begin
    if (rst) ale_d <= 1'b0;
    else     ale_d <= ale;
  end

  assert_addr_held_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(ale_d && !ale) |-> $stable(reg_addr));

  assert_drive_needs_read_R4: assert property (@(posedge clk) disable iff (rst)
    ad_oe |-> !rd_n);

  assert_write_blocks_drive_R9: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> (!ad_oe && !reg_rd_stb));

  assert_reset_inputs_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!dir_a && !dir_b && !ad_oe));

  assert_wr_stb_single_R11: assert property (@(posedge clk) disable iff (rst)
    reg_wr_stb |=> !reg_wr_stb);

  assert_rd_stb_single_R11: assert property (@(posedge clk) disable iff (rst)
    reg_rd_stb |=> !reg_rd_stb);

  assert_wr_stb_offset_R11: assert property (@(posedge clk) disable iff (rst)
    reg_wr_stb |-> (reg_addr != '0 && reg_addr < OFF_W'(6)));
endmodule

bind mbus_frontend mbus_chk #(.OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst(rst), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
  .ad_oe(ad_oe), .reg_addr(reg_addr), .reg_wr_stb(reg_wr_stb),
  .reg_rd_stb(reg_rd_stb), .dir_a(dir_a), .dir_b(dir_b)
);

// File: tb/mbus_frontend_test.sv
`timescale 1ns/1ps
module mbus_frontend_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ale = 1'b0, chip_en = 1'b1, io_sel = 1'b0;
  logic       rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] ad_in = 8'h00;
  logic [7:0] ad_out, reg_wdata, reg_rdata;
  logic       ad_oe, reg_wr_stb, reg_rd_stb, dir_a, dir_b;
  logic [2:0] reg_addr;
  logic [1:0] pc_mode;
  // second build with the opposite chip-select polarity
  logic [7:0] h_out, h_wdata, h_rdata;
  logic       h_oe, h_wstb, h_rstb, h_da, h_db;
  logic [2:0] h_addr;
  logic [1:0] h_pc;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  assign reg_rdata = {5'b10100, reg_addr};
  assign h_rdata   = {5'b10100, h_addr};

  mbus_frontend uut (
    .clk(clk), .rst(rst), .ale(ale), .chip_en(chip_en), .io_sel(io_sel),
    .rd_n(rd_n), .wr_n(wr_n), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr_stb(reg_wr_stb),
    .reg_rd_stb(reg_rd_stb), .reg_rdata(reg_rdata), .dir_a(dir_a),
    .dir_b(dir_b), .pc_mode(pc_mode)
  );

  mbus_frontend #(.CE_HIGH(1'b1)) uut_hi (
    .clk(clk), .rst(rst), .ale(ale), .chip_en(chip_en), .io_sel(io_sel),
    .rd_n(rd_n), .wr_n(wr_n), .ad_in(ad_in), .ad_out(h_out), .ad_oe(h_oe),
    .reg_addr(h_addr), .reg_wdata(h_wdata), .reg_wr_stb(h_wstb),
    .reg_rd_stb(h_rstb), .reg_rdata(h_rdata), .dir_a(h_da),
    .dir_b(h_db), .pc_mode(h_pc)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // capture address; ce_pin is the raw pin level (0 selects uut)
  task automatic bus_latch(input logic [7:0] a, input logic ce_pin, input logic io);
    @(negedge clk); ale = 1'b1; ad_in = a; chip_en = ce_pin; io_sel = io;
    @(negedge clk); ale = 1'b0;
    @(negedge clk); ad_in = 8'hA5;
  endtask

  task automatic bus_write(input logic [7:0] d, output logic stb,
                           output logic [2:0] ra, output logic [7:0] wd);
    @(negedge clk); ad_in = d; wr_n = 1'b0;
    #1 stb = reg_wr_stb; ra = reg_addr; wd = reg_wdata;
    @(negedge clk); wr_n = 1'b1;
  endtask

  task automatic bus_read(output logic oe, output logic [7:0] d, output logic stb);
    @(negedge clk); rd_n = 1'b0;
    #1 oe = ad_oe; d = ad_out; stb = reg_rd_stb;
    @(negedge clk); rd_n = 1'b1;
  endtask

  task automatic mem_wr(input logic [7:0] a, input logic [7:0] d);
    logic s; logic [2:0] r; logic [7:0] w;
    bus_latch(a, 1'b0, 1'b0);
    bus_write(d, s, r, w);
  endtask

  task automatic mem_expect(input string req, input logic [7:0] a, input logic [7:0] d);
    logic oe, s; logic [7:0] q;
    bus_latch(a, 1'b0, 1'b0);
    bus_read(oe, q, s);
    check(req, {7'd0, oe, q}, {8'h01, d});
  endtask

  task automatic t_reset;
    check("R7 oe after reset", {15'd0, ad_oe}, 16'h0000);
    check("R7 dirs after reset", {12'd0, pc_mode, dir_b, dir_a}, 16'h0000);
    check("R11 no strobes after reset", {14'd0, reg_wr_stb, reg_rd_stb}, 16'h0000);
  endtask

  task automatic t_memory;
    mem_wr(8'h00, 8'h3C);
    mem_wr(8'h7F, 8'hC3);
    mem_wr(8'hFF, 8'h81);
    mem_wr(8'h12, 8'h5E);
    mem_expect("R3 R5 mem 00", 8'h00, 8'h3C);
    mem_expect("R3 R5 mem 7F", 8'h7F, 8'hC3);
    mem_expect("R1 R5 mem FF", 8'hFF, 8'h81);
    mem_expect("R4 mem 12", 8'h12, 8'h5E);
  endtask

  task automatic t_long_write;
    // R5: only the first cycle of a held write is stored
    bus_latch(8'h21, 1'b0, 1'b0);
    @(negedge clk); ad_in = 8'h4B; wr_n = 1'b0;
    @(negedge clk); ad_in = 8'hB4;
    @(negedge clk); ad_in = 8'hEE;
    @(negedge clk); wr_n = 1'b1;
    mem_expect("R5 held write", 8'h21, 8'h4B);
  endtask

  task automatic t_held_select;
    logic oe, s; logic [7:0] q;
    // R2: pins flip after capture, memory still answers
    bus_latch(8'h7F, 1'b0, 1'b0);
    @(negedge clk); chip_en = 1'b1; io_sel = 1'b1;
    bus_read(oe, q, s);
    check("R2 held select", {7'd0, oe, q}, {8'h01, 8'hC3});
    check("R2 no register strobe", {15'd0, s}, 16'h0000);
  endtask

  task automatic t_deselected;
    logic oe, s; logic [7:0] q; logic ws; logic [2:0] r; logic [7:0] w;
    bus_latch(8'h12, 1'b1, 1'b0);
    bus_read(oe, q, s);
    check("R4 deselected no drive", {15'd0, oe}, 16'h0000);
    bus_write(8'hEE, ws, r, w);
    mem_expect("R5 deselected write ignored", 8'h12, 8'h5E);
    // idle with selected address but read high
    @(negedge clk); #1;
    check("R4 read high no drive", {15'd0, ad_oe}, 16'h0000);
  endtask

  task automatic t_command;
    logic oe, s; logic [7:0] q; logic ws; logic [2:0] r; logic [7:0] w;
    bus_latch(8'h00, 1'b0, 1'b1);
    bus_write(8'h0D, ws, r, w);
    check("R10 no ext strobe on cmd", {15'd0, ws}, 16'h0000);
    check("R10 command fields", {12'd0, pc_mode, dir_b, dir_a}, 16'h000D);
    bus_read(oe, q, s);
    check("R10 status read", {6'd0, s, oe, q}, {8'h03, 8'hA0});
    mem_expect("R3 cmd write spares memory", 8'h00, 8'h3C);
  endtask

  task automatic t_registers;
    logic oe, s; logic [7:0] q; logic ws; logic [2:0] r; logic [7:0] w;
    bus_latch(8'h03, 1'b0, 1'b1);
    bus_write(8'h99, ws, r, w);
    check("R11 ext write strobe", {4'd0, ws, r, w}, {4'd0, 1'b1, 3'd3, 8'h99});
    @(negedge clk); #1;
    check("R11 write strobe one cycle", {15'd0, reg_wr_stb}, 16'h0000);
    bus_read(oe, q, s);
    check("R11 ext read", {6'd0, s, oe, q}, {8'h03, 8'hA3});
    check("R10 dirs kept", {12'd0, pc_mode, dir_b, dir_a}, 16'h000D);
    bus_latch(8'h06, 1'b0, 1'b1);
    bus_write(8'h77, ws, r, w);
    check("R11 unmapped write no strobe", {15'd0, ws}, 16'h0000);
    bus_read(oe, q, s);
    check("R11 unmapped read", {6'd0, s, oe, q}, {8'h01, 8'h00});
    bus_latch(8'hF3, 1'b0, 1'b1);
    bus_read(oe, q, s);
    check("R11 high address unmapped", {6'd0, s, oe, q}, {8'h01, 8'h00});
    mem_expect("R3 register write spares memory", 8'h03, 8'h00 ^ mem_03);
  endtask

  logic [7:0] mem_03 = 8'h00;

  task automatic t_both;
    bus_latch(8'h20, 1'b0, 1'b0);
    @(negedge clk); ad_in = 8'h77; rd_n = 1'b0; wr_n = 1'b0;
    #1 check("R9 no drive with write", {14'd0, ad_oe, reg_rd_stb}, 16'h0000);
    @(negedge clk); rd_n = 1'b1; wr_n = 1'b1;
    mem_expect("R9 write taken", 8'h20, 8'h77);
  endtask

  task automatic t_reset_keep;
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    @(negedge clk); rst = 1'b0;
    #1 check("R7 dirs cleared", {12'd0, pc_mode, dir_b, dir_a}, 16'h0000);
    check("R7 bus idle", {15'd0, ad_oe}, 16'h0000);
    mem_expect("R8 memory kept 7F", 8'h7F, 8'hC3);
    mem_expect("R8 memory kept 20", 8'h20, 8'h77);
  endtask

  task automatic t_polarity;
    logic ws; logic [2:0] r; logic [7:0] w;
    bus_latch(8'h40, 1'b1, 1'b0);
    bus_write(8'h5A, ws, r, w);
    @(negedge clk); rd_n = 1'b0;
    #1 check("R6 high build selected", {7'd0, h_oe, h_out}, {8'h01, 8'h5A});
    check("R6 low build idle", {15'd0, ad_oe}, 16'h0000);
    @(negedge clk); rd_n = 1'b1;
    bus_latch(8'h40, 1'b0, 1'b0);
    @(negedge clk); rd_n = 1'b0;
    #1 check("R6 high build idle", {15'd0, h_oe}, 16'h0000);
    check("R6 low build untouched", {7'd0, ad_oe, ad_out}, {8'h01, 8'h00 ^ mem_40});
    @(negedge clk); rd_n = 1'b1;
  endtask

  logic [7:0] mem_40 = 8'h00;

  initial begin
    // known memory contents at two spots the tests read without writing
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    t_reset();
    mem_wr(8'h03, 8'h00);
    mem_wr(8'h40, 8'h00);
    t_memory();
    t_long_write();
    t_held_select();
    t_deselected();
    t_command();
    t_registers();
    t_both();
    t_reset_keep();
    t_polarity();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule